// File: doc/BRIEF.md
# Radix-4 Constant-Geometry NTT Butterfly

This block is the arithmetic core of a radix-4 number theoretic transform engine for lattice cryptography. Each cycle it can take one butterfly operation. An operation is four coefficients, three twiddle factors and a direction bit. Four results modulo a prime `P` come out a fixed number of cycles later. The fourth root of unity is not an input. It is derived from `P` at elaboration time.

In the forward direction the block applies the constant-geometry radix-4 equations. The first level multiplies by the twiddles, the second level multiplies by the fourth root. In the inverse direction the equations run in mirror order. A halving step is folded into both internal levels, so no separate scaling pass over the array is needed. The halving costs only an adder and a shift. Memory, address sequencing and twiddle storage belong to the surrounding engine.

The modulus and the coefficient width are parameters. The three prime/width pairs of interest are 7681/13, 8380417/23 and 12289/14.

Top module: `ntt_r4_bfly`

## Requirements
- R1: With `inv_mode`=0, let T0=x0+x2·w2, T1=x0−x2·w2, T2=x1·w1+x3·w3 and T3=x1·w1−x3·w3 (mod P). The outputs are then z0=T0+T2, z1=T1+T3·w4, z2=T0−T2 and z3=T1−T3·w4 (mod P).
- R2: With `inv_mode`=1, let h(v)=v·2⁻¹ mod P, and let U0=h(x0+x2), U1=h(x2−x0)·w4, U2=h(x1+x3) and U3=h(x3−x1). The outputs are then z0=h(U0+U2), z1=h(U1+U3)·w1, z2=h(U2−U0)·w2 and z3=h(U3−U1)·w3.
- R3: Latency is exactly 4 clock edges. `out_valid` is `in_valid` delayed by 4 edges. A new operation is accepted on every cycle, back to back.
- R4: When all inputs lie in [0,P), every output and every internal stage value lies in [0,P).
- R5: The built-in constant w4 satisfies w4² ≡ P−1. The forward probe x=(0,0,0,1), w=(1,1,P−1) yields z=(P−1, w4, 1, P−w4).
- R6: All-zero coefficients give all-zero outputs in either mode, whatever the twiddles.
- R7: The direction bit is captured with each operation. Forward and inverse operations may alternate on consecutive cycles without affecting one another.
- R8: After reset `out_valid` is 0. It stays 0 until 4 edges after the first accepted operation.
- R9: The parameters `P` and `W` configure the block for 7681/13, 8380417/23 and 12289/14.
- R10: Halving an odd residue v gives (v+P)/2. For the inverse operation x=(1,0,0,0) with all twiddles 1, the outputs are (4⁻¹, −w4·4⁻¹, −4⁻¹, w4·4⁻¹) mod P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| inv_mode | input | 1 | 0 forward, 1 inverse |
| x0 | input | W | Coefficient lane 0 |
| x1 | input | W | Coefficient lane 1 |
| x2 | input | W | Coefficient lane 2 |
| x3 | input | W | Coefficient lane 3 |
| w1 | input | W | Twiddle for lane 1 |
| w2 | input | W | Twiddle for lane 2 |
| w3 | input | W | Twiddle for lane 3 |
| out_valid | output | 1 | Results present on the outputs |
| z0 | output | W | Result lane 0 |
| z1 | output | W | Result lane 1 |
| z2 | output | W | Result lane 2 |
| z3 | output | W | Result lane 3 |

## Verification
Some behaviour is checked by assertions on every cycle:
- the 4-edge alignment of `out_valid` with `in_valid`;
- the range of every output and every stage register;
- the mapping of zero coefficients to zero results.

The exact values of both transform directions can only be shown by the bench scenarios. The same holds for the derived fourth root, the odd-halving path and mode interleaving. The bench compares randomized and directed operations, for all three moduli, against a remainder-operator model.

// File: rtl/ntt_r4_pkg.sv
package ntt_r4_pkg;
  localparam int unsigned NLANE = 4;
  localparam int unsigned NTW   = NLANE - 1;

  function automatic longint unsigned pow_mod(longint unsigned b, longint unsigned e,
                                              longint unsigned m);
    longint unsigned r;
    longint unsigned bb;
    longint unsigned ee;
    r  = 1;
    bb = b % m;
    ee = e;
    for (int i = 0; i < 64; i++) begin
      if (ee[0]) r = (r * bb) % m;
      bb = (bb * bb) % m;
      ee = ee >> 1;
    end
    return r;
  endfunction

  // Square root of -1 mod p: a^((p-1)/4) for the first non-residue a.
  function automatic longint unsigned find_w4(longint unsigned p);
    longint unsigned c;
    longint unsigned res;
    bit found;
    res   = 0;
    found = 1'b0;
    for (int a = 2; a < 64; a++) begin
      if (!found) begin
        c = pow_mod(longint'(a), (p - 1) / 4, p);
        if ((c * c) % p == p - 1) begin
          res   = c;
          found = 1'b1;
        end
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/ntt_r4_modmul.sv
module ntt_r4_modmul #(
  parameter int unsigned W = 13,
  parameter int unsigned P = 7681
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  localparam int unsigned PW = 2 * W;
  localparam logic [PW-1:0] PX = PW'(P);

  logic [PW-1:0] prod;
  logic [PW-1:0] acc;

  // Greedy subtraction of P<<k, top down: each step halves the bound.
  always_comb begin
    prod = PW'(a) * PW'(b);
    acc  = prod;
    for (int k = W; k >= 0; k--) begin
      if (acc >= (PX << k)) acc = acc - (PX << k);
    end
    r = acc[W-1:0];
  end
endmodule

// File: rtl/ntt_r4_pipe_reg.sv
module ntt_r4_pipe_reg #(
  parameter int unsigned W = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       d_vld,
  input  logic                       d_inv,
  input  logic [3:0][W-1:0]          d_lane,
  input  logic [2:0][W-1:0]          d_tw,
  output logic                       q_vld,
  output logic                       q_inv,
  output logic [3:0][W-1:0]          q_lane,
  output logic [2:0][W-1:0]          q_tw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_inv  <= 1'b0;
      q_lane <= '0;
      q_tw   <= '0;
    end else begin
      q_vld  <= d_vld;
      q_inv  <= d_inv;
      q_lane <= d_lane;
      q_tw   <= d_tw;
    end
  end
endmodule

// File: rtl/ntt_r4_bfly.sv
module ntt_r4_bfly #(
  parameter int unsigned W = 13,
  parameter int unsigned P = 7681
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         inv_mode,
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  input  logic [W-1:0] w1,
  input  logic [W-1:0] w2,
  input  logic [W-1:0] w3,
  output logic         out_valid,
  output logic [W-1:0] z0,
  output logic [W-1:0] z1,
  output logic [W-1:0] z2,
  output logic [W-1:0] z3
);
  localparam int unsigned NST = 4;
  localparam logic [W:0] PW1 = (W+1)'(P);
  localparam longint unsigned W4L = ntt_r4_pkg::find_w4(longint'(P));
  localparam logic [W-1:0] W4C = W4L[W-1:0];

  // ---- modular helpers (one conditional correction each) ----
  function automatic logic [W-1:0] f_add(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= PW1) s = s - PW1;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] f_sub(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} - {1'b0, b};
    if (a < b) s = s + PW1;
    return s[W-1:0];
  endfunction

  // Halving mod P: even values shift, odd values add P first.
  function automatic logic [W-1:0] f_half(logic [W-1:0] v);
    logic [W:0] s;
    s = {1'b0, v} + (v[0] ? PW1 : '0);
    return s[W:1];
  endfunction

  // ---- pipeline state: index 0 is the input, NST the output ----
  logic                vld  [0:NST];
  logic                inv  [0:NST];
  logic [3:0][W-1:0]   lane [0:NST];
  logic [2:0][W-1:0]   tw   [0:NST];
  logic [3:0][W-1:0]   nxt  [0:NST-1];

  logic [W-1:0] m_s1 [0:2];
  logic [W-1:0] m_s4 [0:2];
  logic [W-1:0] m_s2;
  logic [W-1:0] m_s3;

  assign vld[0]  = in_valid;
  assign inv[0]  = inv_mode;
  assign lane[0] = {x3, x2, x1, x0};
  assign tw[0]   = {w3, w2, w1};

  generate
    for (genvar k = 0; k < NST; k++) begin : g_stage
      ntt_r4_pipe_reg #(.W(W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_vld (vld[k]),
        .d_inv (inv[k]),
        .d_lane(nxt[k]),
        .d_tw  (tw[k]),
        .q_vld (vld[k+1]),
        .q_inv (inv[k+1]),
        .q_lane(lane[k+1]),
        .q_tw  (tw[k+1])
      );
    end
    for (genvar j = 0; j < 3; j++) begin : g_twmul
      ntt_r4_modmul #(.W(W), .P(P)) u_mul_first (
        .a(lane[0][j+1]), .b(tw[0][j]), .r(m_s1[j]));
      ntt_r4_modmul #(.W(W), .P(P)) u_mul_last (
        .a(lane[3][j+1]), .b(tw[3][j]), .r(m_s4[j]));
    end
  endgenerate

  ntt_r4_modmul #(.W(W), .P(P)) u_mul_root_a (.a(lane[1][1]), .b(W4C), .r(m_s2));
  ntt_r4_modmul #(.W(W), .P(P)) u_mul_root_b (.a(lane[2][3]), .b(W4C), .r(m_s3));

  // Stage 1: forward twiddle products / inverse halved butterfly (R1, R2)
  always_comb begin
    if (inv[0])
      nxt[0] = {f_half(f_sub(lane[0][3], lane[0][1])), f_half(f_add(lane[0][1], lane[0][3])),
                f_half(f_sub(lane[0][2], lane[0][0])), f_half(f_add(lane[0][0], lane[0][2]))};
    else
      nxt[0] = {m_s1[2], m_s1[1], m_s1[0], lane[0][0]};
  end

  // Stage 2: forward T0..T3 / inverse lane-1 times w4
  always_comb begin
    if (inv[1])
      nxt[1] = {lane[1][3], lane[1][2], m_s2, lane[1][0]};
    else
      nxt[1] = {f_sub(lane[1][1], lane[1][3]), f_add(lane[1][1], lane[1][3]),
                f_sub(lane[1][0], lane[1][2]), f_add(lane[1][0], lane[1][2])};
  end

  // Stage 3: forward T3 times w4 / inverse second halved butterfly
  always_comb begin
    if (inv[2])
      nxt[2] = {f_half(f_sub(lane[2][3], lane[2][1])), f_half(f_sub(lane[2][2], lane[2][0])),
                f_half(f_add(lane[2][1], lane[2][3])), f_half(f_add(lane[2][0], lane[2][2]))};
    else
      nxt[2] = {m_s3, lane[2][2], lane[2][1], lane[2][0]};
  end

  // Stage 4: forward final butterfly / inverse twiddle products
  always_comb begin
    if (inv[3])
      nxt[3] = {m_s4[2], m_s4[1], m_s4[0], lane[3][0]};
    else
      nxt[3] = {f_sub(lane[3][1], lane[3][3]), f_sub(lane[3][0], lane[3][2]),
                f_add(lane[3][1], lane[3][3]), f_add(lane[3][0], lane[3][2])};
  end

  assign out_valid = vld[NST];
  assign z0 = lane[NST][0];
  assign z1 = lane[NST][1];
  assign z2 = lane[NST][2];
  assign z3 = lane[NST][3];

  // ---- assertions ----
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  p_out_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (({1'b0, z0} < PW1) && ({1'b0, z1} < PW1) &&
                   ({1'b0, z2} < PW1) && ({1'b0, z3} < PW1)));

  generate
    for (genvar k = 1; k < NST; k++) begin : g_chk
      p_lane_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vld[k] |-> (({1'b0, lane[k][0]} < PW1) && ({1'b0, lane[k][1]} < PW1) &&
                    ({1'b0, lane[k][2]} < PW1) && ({1'b0, lane[k][3]} < PW1)));
    end
  endgenerate

  p_zero_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x0 == '0 && x1 == '0 && x2 == '0 && x3 == '0) |->
      ##4 (out_valid && z0 == '0 && z1 == '0 && z2 == '0 && z3 == '0));
endmodule

// File: tb/ntt_r4_bfly_bench.sv
`timescale 1ns/1ps
module ntt_r4_bfly_bench;
  localparam int unsigned PA = 7681,    WA = 13;
  localparam int unsigned PB = 8380417, WB = 23;
  localparam int unsigned PC = 12289,   WC = 14;
  localparam int MAXOP = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 1'b0;
  logic bm = 1'b0;
  logic [22:0] xin [3][4];
  logic [22:0] win [3][3];
  logic [WA-1:0] za [4];
  logic [WB-1:0] zb [4];
  logic [WC-1:0] zc [4];
  logic va, vb, vc;

  always #10 clk = ~clk;

  ntt_r4_bfly #(.W(WA), .P(PA)) u_ntt_r4_bfly (
    .clk(clk), .rst_n(rst_n), .in_valid(bv), .inv_mode(bm),
    .x0(xin[0][0][WA-1:0]), .x1(xin[0][1][WA-1:0]), .x2(xin[0][2][WA-1:0]), .x3(xin[0][3][WA-1:0]),
    .w1(win[0][0][WA-1:0]), .w2(win[0][1][WA-1:0]), .w3(win[0][2][WA-1:0]),
    .out_valid(va), .z0(za[0]), .z1(za[1]), .z2(za[2]), .z3(za[3]));
  ntt_r4_bfly #(.W(WB), .P(PB)) u_ntt_r4_bfly_b (
    .clk(clk), .rst_n(rst_n), .in_valid(bv), .inv_mode(bm),
    .x0(xin[1][0][WB-1:0]), .x1(xin[1][1][WB-1:0]), .x2(xin[1][2][WB-1:0]), .x3(xin[1][3][WB-1:0]),
    .w1(win[1][0][WB-1:0]), .w2(win[1][1][WB-1:0]), .w3(win[1][2][WB-1:0]),
    .out_valid(vb), .z0(zb[0]), .z1(zb[1]), .z2(zb[2]), .z3(zb[3]));
  ntt_r4_bfly #(.W(WC), .P(PC)) u_ntt_r4_bfly_c (
    .clk(clk), .rst_n(rst_n), .in_valid(bv), .inv_mode(bm),
    .x0(xin[2][0][WC-1:0]), .x1(xin[2][1][WC-1:0]), .x2(xin[2][2][WC-1:0]), .x3(xin[2][3][WC-1:0]),
    .w1(win[2][0][WC-1:0]), .w2(win[2][1][WC-1:0]), .w3(win[2][2][WC-1:0]),
    .out_valid(vc), .z0(zc[0]), .z1(zc[1]), .z2(zc[2]), .z3(zc[3]));

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 1'b0;
  bit sb_on = 1'b0;
  longint unsigned w4v [3];
  longint unsigned cur_x [3][4];
  longint unsigned cur_w [3][3];
  longint unsigned expv [3][0:MAXOP-1][4];
  int issue_cyc [3][0:MAXOP-1];
  string tagq [3][0:MAXOP-1];
  int issued [3];
  int retired [3];
  longint unsigned res [4];

  function automatic longint unsigned pval(int c);
    return (c == 0) ? 64'(PA) : (c == 1) ? 64'(PB) : 64'(PC);
  endfunction
  function automatic bit vout(int c);
    return (c == 0) ? va : (c == 1) ? vb : vc;
  endfunction
  function automatic longint unsigned zout(int c, int j);
    return (c == 0) ? 64'(za[j]) : (c == 1) ? 64'(zb[j]) : 64'(zc[j]);
  endfunction

  function automatic longint unsigned mm(longint unsigned p, longint unsigned a, longint unsigned b);
    return (a * b) % p;
  endfunction
  function automatic longint unsigned ad(longint unsigned p, longint unsigned a, longint unsigned b);
    return (a + b) % p;
  endfunction
  function automatic longint unsigned sb(longint unsigned p, longint unsigned a, longint unsigned b);
    return (a + p - b) % p;
  endfunction
  function automatic longint unsigned hv(longint unsigned p, longint unsigned a);
    return (a * ((p + 1) / 2)) % p;
  endfunction

  // Reference: R1 forward, R2 inverse, written with the remainder operator
  function automatic void model(int c, bit m);
    longint unsigned p, t0, t1, t2, t3, w4;
    p = pval(c);
    w4 = w4v[c];
    if (!m) begin
      t0 = ad(p, cur_x[c][0], mm(p, cur_x[c][2], cur_w[c][1]));
      t1 = sb(p, cur_x[c][0], mm(p, cur_x[c][2], cur_w[c][1]));
      t2 = ad(p, mm(p, cur_x[c][1], cur_w[c][0]), mm(p, cur_x[c][3], cur_w[c][2]));
      t3 = sb(p, mm(p, cur_x[c][1], cur_w[c][0]), mm(p, cur_x[c][3], cur_w[c][2]));
      res[0] = ad(p, t0, t2);
      res[1] = ad(p, t1, mm(p, t3, w4));
      res[2] = sb(p, t0, t2);
      res[3] = sb(p, t1, mm(p, t3, w4));
    end else begin
      t0 = hv(p, ad(p, cur_x[c][0], cur_x[c][2]));
      t1 = mm(p, hv(p, sb(p, cur_x[c][2], cur_x[c][0])), w4);
      t2 = hv(p, ad(p, cur_x[c][1], cur_x[c][3]));
      t3 = hv(p, sb(p, cur_x[c][3], cur_x[c][1]));
      res[0] = hv(p, ad(p, t0, t2));
      res[1] = mm(p, hv(p, ad(p, t1, t3)), cur_w[c][0]);
      res[2] = mm(p, hv(p, sb(p, t2, t0)), cur_w[c][1]);
      res[3] = mm(p, hv(p, sb(p, t3, t1)), cur_w[c][2]);
    end
  endfunction

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    for (int c = 0; c < 3; c++) begin
      if (sb_on) begin
        if (vout(c)) begin
          if (retired[c] >= issued[c]) begin
            chk(1'b0, "R3", $sformatf("cfg%0d unexpected out_valid", c), 1, 0);
          end else begin
            int k;
            k = retired[c];
            // R3: output exactly 4 edges after issue
            chk(cyc - issue_cyc[c][k] == 4, "R3", $sformatf("cfg%0d latency", c),
                longint'(cyc - issue_cyc[c][k]), 4);
            for (int j = 0; j < 4; j++) begin
              chk(zout(c, j) == expv[c][k][j], tagq[c][k],
                  $sformatf("cfg%0d op%0d z%0d", c, k, j), zout(c, j), expv[c][k][j]);
              chk(zout(c, j) < pval(c), "R4", $sformatf("cfg%0d z%0d range", c, j),
                  zout(c, j), pval(c) - 1);
            end
            retired[c]++;
          end
        end else if (retired[c] < issued[c] && issue_cyc[c][retired[c]] + 4 == cyc) begin
          chk(1'b0, "R3", $sformatf("cfg%0d missing out_valid", c), 0, 1);
          retired[c]++;
        end
      end
    end
  endtask

  task automatic tick(bit v, bit m, string tag);
    @(negedge clk);
    cyc++;
    check_outputs();
    bv = v;
    bm = m;
    for (int c = 0; c < 3; c++) begin
      for (int j = 0; j < 4; j++) xin[c][j] = 23'(cur_x[c][j]);
      for (int j = 0; j < 3; j++) win[c][j] = 23'(cur_w[c][j]);
      if (v && sb_on) begin
        model(c, m);
        for (int j = 0; j < 4; j++) expv[c][issued[c]][j] = res[j];
        issue_cyc[c][issued[c]] = cyc;
        tagq[c][issued[c]] = tag;
        issued[c]++;
      end
    end
  endtask

  task automatic rand_set();
    for (int c = 0; c < 3; c++) begin
      for (int j = 0; j < 4; j++) cur_x[c][j] = longint'($urandom) % pval(c);
      for (int j = 0; j < 3; j++) cur_w[c][j] = longint'($urandom) % pval(c);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 3; c++) begin
      issued[c] = 0;
      retired[c] = 0;
      for (int j = 0; j < 4; j++) begin cur_x[c][j] = 0; xin[c][j] = '0; end
      for (int j = 0; j < 3; j++) begin cur_w[c][j] = 0; win[c][j] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: idle after reset
    for (int t = 0; t < 4; t++) begin
      tick(1'b0, 1'b0, "R8");
      for (int c = 0; c < 3; c++)
        chk(vout(c) == 1'b0, "R8", $sformatf("cfg%0d out_valid after reset", c), vout(c), 0);
    end

    // R5 / R9: probe the fourth root in every configuration
    for (int c = 0; c < 3; c++) begin
      cur_x[c][0] = 0; cur_x[c][1] = 0; cur_x[c][2] = 0; cur_x[c][3] = 1;
      cur_w[c][0] = 1; cur_w[c][1] = 1; cur_w[c][2] = pval(c) - 1;
    end
    tick(1'b1, 1'b0, "R5");
    for (int t = 0; t < 3; t++) begin
      tick(1'b0, 1'b0, "R5");
      for (int c = 0; c < 3; c++)
        chk(vout(c) == 1'b0, "R8", $sformatf("cfg%0d early out_valid", c), vout(c), 0);
    end
    tick(1'b0, 1'b0, "R5");
    for (int c = 0; c < 3; c++) begin
      longint unsigned p;
      p = pval(c);
      w4v[c] = zout(c, 1);
      chk(vout(c) == 1'b1, "R3", $sformatf("cfg%0d probe valid", c), vout(c), 1);
      chk((w4v[c] * w4v[c]) % p == p - 1, "R5/R9", $sformatf("cfg%0d w4 squared", c),
          (w4v[c] * w4v[c]) % p, p - 1);
      chk(zout(c, 0) == p - 1, "R5", $sformatf("cfg%0d probe z0", c), zout(c, 0), p - 1);
      chk(zout(c, 2) == 1, "R5", $sformatf("cfg%0d probe z2", c), zout(c, 2), 1);
      chk(zout(c, 3) == (p - w4v[c]) % p, "R5", $sformatf("cfg%0d probe z3", c),
          zout(c, 3), (p - w4v[c]) % p);
    end
    sb_on = 1'b1;

    // R6: zero coefficients, both modes, random twiddles
    rand_set();
    for (int c = 0; c < 3; c++) for (int j = 0; j < 4; j++) cur_x[c][j] = 0;
    tick(1'b1, 1'b0, "R6");
    tick(1'b1, 1'b1, "R6");

    // R4: everything at P-1, both modes
    for (int c = 0; c < 3; c++) begin
      for (int j = 0; j < 4; j++) cur_x[c][j] = pval(c) - 1;
      for (int j = 0; j < 3; j++) cur_w[c][j] = pval(c) - 1;
    end
    tick(1'b1, 1'b0, "R1/R4");
    tick(1'b1, 1'b1, "R2/R4");

    // R10: odd halving path
    for (int c = 0; c < 3; c++) begin
      cur_x[c][0] = 1; cur_x[c][1] = 0; cur_x[c][2] = 0; cur_x[c][3] = 0;
      for (int j = 0; j < 3; j++) cur_w[c][j] = 1;
    end
    tick(1'b1, 1'b1, "R10");

    // R7: back-to-back alternating modes
    for (int n = 0; n < 24; n++) begin
      rand_set();
      tick(1'b1, n[0], n[0] ? "R2/R7" : "R1/R7");
    end

    // R1 / R2 / R9: random traffic with gaps
    for (int n = 0; n < 600; n++) begin
      bit v, m;
      v = ($urandom % 5) != 0;
      m = $urandom % 2;
      rand_set();
      tick(v, m, m ? "R2/R9" : "R1/R9");
    end

    for (int t = 0; t < 6; t++) tick(1'b0, 1'b0, "R3");
    for (int c = 0; c < 3; c++)
      chk(retired[c] == issued[c], "R3", $sformatf("cfg%0d drained", c), retired[c], issued[c]);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule